// File: doc/BRIEF.md
# Edge-Interval Wake-Up Qualifier

This block decides whether a polling receiver has found a genuine data stream and should move from its periodic listening phase into full receive mode. Once enabled it first runs a fixed blanking period, counted in time-base ticks, during which the demodulated data line is treated as meaningless. It then waits for a first transition on the line and measures every following gap between transitions with a tick counter.

Each measured gap must land inside a programmable window. A gap that ends too early fails the qualification. A gap that runs on until the counter would reach the upper limit fails at once, without waiting for the next transition. When the required number of consecutive in-window gaps has been seen, the block raises a single-cycle pass pulse and parks in receive mode until enable is withdrawn. A failure sends it back to idle.

The data line is resynchronised with a two-stage flop chain. Rising and falling transitions both count, so each data bit provides two half-bit gaps.

Top module: `ewc_bit_validator`

## Requirements
- R1: After reset, `check_pass`, `check_fail` and `busy` are low and `interval_count` is 0.
- R2: When `enable` rises, the block spends STARTUP_TICKS ticks in a blanking phase. In that phase `busy` is high, `interval_count` stays 0, and transitions on `rx_data` cause no failure.
- R3: The first transition after blanking is not judged. It starts timing, and `interval_count` becomes 1.
- R4: While a gap is being timed, each `tick` pulse raises `interval_count` by one.
- R5: A transition that arrives while `interval_count` is below `lim_lo` fails the check. `check_fail` is high for one clock, and the block returns to idle with `interval_count` at 0.
- R6: If a tick would bring `interval_count` up to `lim_hi`, the check fails on that tick with no transition needed. The count therefore never shows `lim_hi` while a gap is being timed.
- R7: A rising or falling transition with `lim_lo <= interval_count <= lim_hi-1` accepts the gap, and `interval_count` restarts at 1.
- R8: `bits_sel` sets how many bits must qualify: 0 gives 3 bits, 1 gives 6, and 2 or 3 give 9. The number of gaps required is twice the bit count. When the last required gap is accepted, `check_pass` is high for one clock. After that `busy` is low and the block stays in receive mode.
- R9: Lowering `enable` returns the block to idle on the next clock from any state. `busy` goes low and `interval_count` goes to 0.
- R10: `check_pass` and `check_fail` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Starts qualification when high; forces idle when low |
| rx_data | input | 1 | Asynchronous demodulated data line |
| tick | input | 1 | One-clock time-base pulse |
| lim_lo | input | 6 | Lowest accepted gap length in ticks |
| lim_hi | input | 6 | Gap length at which the check aborts |
| bits_sel | input | 2 | Number of bits to qualify (encoding in R8) |
| check_pass | output | 1 | One-clock pulse when qualification succeeds |
| check_fail | output | 1 | One-clock pulse when a gap is rejected |
| busy | output | 1 | High during blanking and gap checking |
| interval_count | output | 6 | Ticks counted in the current gap |

## Verification
The bench aims directly at the window edges. It uses gaps of exactly `lim_lo` and exactly `lim_hi-1` ticks, which must pass, and a gap of `lim_lo-1`, which must fail. A design with an off-by-one comparison would fail the first case or accept the last. Overlong gaps check that the abort comes on the tick that reaches `lim_hi`, not on a later transition. Rapid toggling during blanking checks that the startup data is ignored; a design that timed it would report an early failure. Full sequences at every `bits_sel` value check that the pass pulse comes on the exact final gap and not one gap early or late. Random windows and gap mixes are added to these directed cases.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

  parameter int unsigned CW = 6;
  parameter int unsigned GW = 5;

  typedef logic [CW-1:0] cnt_t;
  typedef logic [GW-1:0] gap_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BLANK = 3'd1,
    ST_ARM   = 3'd2,
    ST_CHECK = 3'd3,
    ST_RECV  = 3'd4
  } ewc_state_e;

  // gaps required = two half-bit gaps per qualified bit
  function automatic gap_t gaps_needed(input logic [1:0] sel);
    case (sel)
      2'd0:    gaps_needed = gap_t'(6);
      2'd1:    gaps_needed = gap_t'(12);
      default: gaps_needed = gap_t'(18);
    endcase
  endfunction

  function automatic logic gap_too_short(input cnt_t cnt, input cnt_t lo);
    gap_too_short = (cnt < lo);
  endfunction

  function automatic logic gap_at_ceiling(input cnt_t cnt, input cnt_t hi);
    gap_at_ceiling = ({1'b0, cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, hi};
  endfunction

endpackage

// File: rtl/ewc_edge_sync.sv
module ewc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];

  assign level_o = chain_q[STAGES-1];
  assign edge_o  = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/ewc_interval_timer.sv
module ewc_interval_timer
  import ewc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic load_one_i,
  input  logic step_i,
  output cnt_t cnt_o
);
  cnt_t cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (load_one_i) cnt_q <= cnt_t'(1);
    else if (step_i)     cnt_q <= cnt_q + cnt_t'(1);

  assign cnt_o = cnt_q;

  // R4
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && !load_one_i) |=> (cnt_q == $past(cnt_q) + cnt_t'(1)));

endmodule

// File: rtl/ewc_seq_ctrl.sv
module ewc_seq_ctrl
  import ewc_pkg::*;
#(
  parameter int STARTUP_TICKS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       edge_i,
  input  cnt_t       lo_i,
  input  cnt_t       hi_i,
  input  logic [1:0] sel_i,
  input  cnt_t       cnt_i,
  output logic       clear_o,
  output logic       load_one_o,
  output logic       step_o,
  output logic       pass_o,
  output logic       fail_o,
  output logic       busy_o
);
  localparam int SW = $clog2(STARTUP_TICKS + 1);

  ewc_state_e st_q, st_d;
  logic [SW-1:0] blank_q, blank_d;
  gap_t gaps_q, gaps_d;
  logic pass_q, pass_d, fail_q, fail_d;

  // named events for assertions
  logic evt_short, evt_long, evt_accept, evt_last;
  gap_t need;

  assign need       = gaps_needed(sel_i);
  assign evt_short  = (st_q == ST_CHECK) && edge_i && gap_too_short(cnt_i, lo_i);
  assign evt_accept = (st_q == ST_CHECK) && edge_i && !gap_too_short(cnt_i, lo_i);
  assign evt_long   = (st_q == ST_CHECK) && !edge_i && tick_i && gap_at_ceiling(cnt_i, hi_i);
  assign evt_last   = evt_accept && ((gaps_q + gap_t'(1)) == need);

  always_comb begin
    st_d       = st_q;
    blank_d    = blank_q;
    gaps_d     = gaps_q;
    pass_d     = 1'b0;
    fail_d     = 1'b0;
    clear_o    = 1'b0;
    load_one_o = 1'b0;
    step_o     = 1'b0;
    if (!en_i) begin
      st_d    = ST_IDLE;
      clear_o = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_d    = ST_BLANK;
          blank_d = '0;
          clear_o = 1'b1;
        end
        ST_BLANK: begin
          clear_o = 1'b1;
          if (tick_i) begin
            if (blank_q == SW'(STARTUP_TICKS - 1)) st_d = ST_ARM;
            else                                   blank_d = blank_q + SW'(1);
          end
        end
        ST_ARM: begin
          if (edge_i) begin
            load_one_o = 1'b1;
            gaps_d     = '0;
            st_d       = ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (evt_short || evt_long) begin
            fail_d  = 1'b1;
            clear_o = 1'b1;
            st_d    = ST_IDLE;
          end else if (evt_accept) begin
            load_one_o = 1'b1;
            if (evt_last) begin
              pass_d = 1'b1;
              st_d   = ST_RECV;
            end else begin
              gaps_d = gaps_q + gap_t'(1);
            end
          end else if (tick_i) begin
            step_o = 1'b1;
          end
        end
        ST_RECV: st_d = ST_RECV;
        default: begin
          st_d    = ST_IDLE;
          clear_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      blank_q <= '0;
      gaps_q  <= '0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      blank_q <= blank_d;
      gaps_q  <= gaps_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
    end

  assign pass_o = pass_q;
  assign fail_o = fail_q;
  assign busy_o = (st_q == ST_BLANK) || (st_q == ST_ARM) || (st_q == ST_CHECK);

  // R10
  pass_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_q && fail_q));

  // R6
  below_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && $stable(hi_i)) |-> (cnt_i < hi_i));

  // R8
  pass_to_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> (st_q == ST_RECV));

  // R5
  fail_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> (st_q == ST_IDLE && cnt_i == '0));

  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st_q == ST_IDLE));

  // R2
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BLANK) |-> (cnt_i == '0 && !fail_q));

endmodule

// File: rtl/ewc_bit_validator.sv
module ewc_bit_validator
  import ewc_pkg::*;
#(
  parameter int STARTUP_TICKS = 6,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       rx_data,
  input  logic       tick,
  input  logic [5:0] lim_lo,
  input  logic [5:0] lim_hi,
  input  logic [1:0] bits_sel,
  output logic       check_pass,
  output logic       check_fail,
  output logic       busy,
  output logic [5:0] interval_count
);
  logic rx_level, rx_edge;
  logic clr, ld1, stp;
  cnt_t cnt;

  ewc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (rx_data),
    .level_o (rx_level),
    .edge_o  (rx_edge)
  );

  ewc_interval_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clr),
    .load_one_i (ld1),
    .step_i     (stp),
    .cnt_o      (cnt)
  );

  ewc_seq_ctrl #(.STARTUP_TICKS(STARTUP_TICKS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (enable),
    .tick_i     (tick),
    .edge_i     (rx_edge),
    .lo_i       (cnt_t'(lim_lo)),
    .hi_i       (cnt_t'(lim_hi)),
    .sel_i      (bits_sel),
    .cnt_i      (cnt),
    .clear_o    (clr),
    .load_one_o (ld1),
    .step_o     (stp),
    .pass_o     (check_pass),
    .fail_o     (check_fail),
    .busy_o     (busy)
  );

  assign interval_count = 6'(cnt);

  logic unused_level;
  assign unused_level = rx_level;

endmodule

// File: tb/test_ewc_bit_validator.sv
module test_ewc_bit_validator;
  localparam int STARTUP = 6;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, rx_data = 1'b0, tick = 1'b0;
  logic [5:0] lim_lo = 6'd10, lim_hi = 6'd20;
  logic [1:0] bits_sel = 2'd0;
  logic check_pass, check_fail, busy;
  logic [5:0] interval_count;

  int n_cmp = 0, n_bad = 0;
  int pass_n = 0, fail_n = 0;
  int plan_q[$];

  always #10 clk = ~clk;

  ewc_bit_validator #(.STARTUP_TICKS(STARTUP)) i_ewc_bit_validator (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rx_data(rx_data), .tick(tick),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .bits_sel(bits_sel),
    .check_pass(check_pass), .check_fail(check_fail), .busy(busy),
    .interval_count(interval_count)
  );

  always @(negedge clk) if (rst_n) begin
    if (check_pass) pass_n++;
    if (check_fail) fail_n++;
  end

  function automatic int exp_gaps(input int sel);
    if (sel == 0) return 6;
    if (sel == 1) return 12;
    return 18;
  endfunction

  // 0 accept, 1 short, 2 long; a gap of m ticks ends with count m+1
  function automatic int judge(input int m, input int lo, input int hi);
    if (m + 1 >= hi) return 2;
    if (m + 1 < lo) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one time-base period: tick at first clock, optional data toggle after it
  task automatic slot(input bit tog);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (tog) rx_data = ~rx_data;
    repeat (3) @(negedge clk);
  endtask

  task automatic start_and_arm();
    enable = 1'b1;
    @(negedge clk);
    for (int s = 1; s <= STARTUP; s++) begin
      slot(s < STARTUP);
      #1;
      chk("R2 blank busy", busy, 1);
      chk("R2 blank count", interval_count, 0);
      chk("R2 blank no fail", fail_n, 0 + fail_base);
    end
    slot(1'b1);
    chk("R3 first edge count", interval_count, 1);
  endtask

  int fail_base = 0;

  task automatic run_plan(input int lo, input int hi, input int sel, input bit drop_chk);
    int need, p0, f0, v, m;
    lim_lo = 6'(lo); lim_hi = 6'(hi); bits_sel = 2'(sel);
    fail_base = fail_n;
    start_and_arm();
    need = exp_gaps(sel);
    for (int i = 0; i < plan_q.size(); i++) begin
      m = plan_q[i];
      p0 = pass_n; f0 = fail_n;
      v = judge(m, lo, hi);
      if (v == 2) begin
        repeat (hi - 1) slot(1'b0);
        #1;
        chk("R6 long gap fail", fail_n, f0 + 1);
        chk("R6 no pass", pass_n, p0);
        break;
      end
      repeat (m - 1) slot(1'b0);
      slot(1'b1);
      #1;
      if (v == 1) begin
        chk("R5 short gap fail", fail_n, f0 + 1);
        chk("R5 count cleared", interval_count, 0);
        break;
      end else if (i == need - 1) begin
        chk("R8 pass pulse", pass_n, p0 + 1);
        chk("R10 no fail with pass", fail_n, f0);
        @(negedge clk); #1;
        chk("R8 busy low in receive", busy, 0);
        break;
      end else begin
        chk("R7 gap accepted no pulse", pass_n + fail_n, p0 + f0);
        chk("R7 count restart", interval_count, 1);
      end
    end
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk); #1;
    if (drop_chk) begin
      chk("R9 idle busy", busy, 0);
      chk("R9 idle count", interval_count, 0);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lo, hi, sel, r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset pass", check_pass, 0);
    chk("R1 reset fail", check_fail, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset count", interval_count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // window edges exact: lo and hi-1, 3 bits
    plan_q = '{9, 18, 9, 18, 9, 18};
    run_plan(10, 20, 0, 1'b1);
    // gap one below lo
    plan_q = '{9, 8};
    run_plan(10, 20, 0, 1'b1);
    // overlong gap
    plan_q = '{11, 15};
    run_plan(12, 16, 1, 1'b1);
    // sel 3 means 9 bits
    plan_q.delete();
    for (int i = 0; i < 18; i++) plan_q.push_back(13);
    run_plan(12, 16, 3, 1'b1);
    // sel 1 means 6 bits
    plan_q.delete();
    for (int i = 0; i < 12; i++) plan_q.push_back(11);
    run_plan(10, 14, 1, 1'b1);

    // R4 stepping and R9 abort mid-check
    lim_lo = 6'd10; lim_hi = 6'd30; bits_sel = 2'd2;
    fail_base = fail_n;
    start_and_arm();
    for (int j = 1; j <= 3; j++) begin
      slot(1'b0);
      #1;
      chk("R4 count step", interval_count, 1 + j);
    end
    enable = 1'b0;
    @(negedge clk); #1;
    chk("R9 abort busy", busy, 0);
    chk("R9 abort count", interval_count, 0);
    repeat (2) @(negedge clk);

    // random windows and gap mixes
    for (int k = 0; k < 20; k++) begin
      lo  = 10 + int'($urandom % 11);
      hi  = lo + 1 + int'($urandom % 15);
      sel = int'($urandom % 4);
      plan_q.delete();
      for (int i = 0; i < exp_gaps(sel); i++) begin
        r = int'($urandom % 100);
        if (r < 88)      plan_q.push_back(lo - 1 + int'($urandom % (hi - lo)));
        else if (r < 94) plan_q.push_back(1 + int'($urandom % (lo - 2)));
        else             plan_q.push_back(hi - 1);
      end
      run_plan(lo, hi, sel, k[0]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule